// File: doc/BRIEF.md
# Inline Memory Encryption Address Router

This block sits on the path from a processor bus to external RAM. Each access carries a 40-bit physical address and one 16-byte data unit. The router checks whether the address falls inside one of two alias windows. Both windows reach the same RAM, and each window belongs to its own cipher channel. For an access inside a window, the router strips the alias bits to form the RAM address. It derives a per-block tweak from the resulting physical address and passes the data unit through the channel's cipher. An address outside both windows goes through untouched.

Each channel holds a small configuration word: cipher mode, key length and enable. It also holds a 256-bit key that is filled one 32-bit word at a time, straight from a key-generator result port. The key never travels over the data path. The cipher is a keyed XOR stand-in, so the whole block can be verified on its own. Because the stand-in is an XOR, one transform serves both the write direction (plaintext to RAM) and the read direction (ciphertext from RAM, paired with its address by the caller). The cipher output carries no integrity tag. All outputs are registered, with one cycle of latency.

Top module: `imc_addr_router`

## Requirements
- R1: An address whose bits 39..32 equal 0x88 is handled by channel 0, and one whose bits 39..32 equal 0xC8 is handled by channel 1; `out_ch` reports the channel.
- R2: Inside either window, `out_addr` is the RAM base 0x08_0000_0000 with the low 32 address bits kept.
- R3: An address outside both windows leaves with address and data unchanged, `out_enc` low and `out_err` low.
- R4: `out_tweak` equals the output RAM address shifted right by 4, i.e. the index of the 16-byte block.
- R5: In mode 0, the output data is the input data XOR the channel key part.
- R6: In mode 1, the output data is the input data XOR the key part XOR the tweak placed in bits 127..92.
- R7: In mode 2, the output data is the input data XOR the key part XOR the tweak zero-extended into bits 35..0.
- R8: With the long-key flag set, the key part is key bits 127..0 XOR key bits 255..128. With the flag clear, the key part is key bits 127..0 alone, and the upper key words have no effect.
- R9: When a window's channel has its enable clear, or has mode 3, the access returns `out_err` high, zero data, `out_enc` low and `out_write` low.
- R10: A key load writes `key_word` into bits 32*idx+31..32*idx of the selected channel's key only, where idx is `key_idx`.
- R11: Outputs follow inputs by one clock: `out_valid` is the previous cycle's `in_valid`. After reset, `out_valid` is low, both channels are disabled and both keys are zero.
- R12: Applying the same channel, address and configuration to a transformed unit returns the original data, so the same path serves reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the configuration of channel `cfg_ch` |
| cfg_ch | input | 1 | Channel to configure |
| cfg_mode | input | 2 | Mode: 0 ECB, 1 CBC, 2 XEX, 3 reserved |
| cfg_k256 | input | 1 | Long-key flag |
| cfg_en | input | 1 | Channel enable |
| key_ld | input | 1 | Load one key word |
| key_ch | input | 1 | Channel whose key is loaded |
| key_idx | input | 3 | Word index within the key |
| key_word | input | 32 | Key-generator result word |
| in_valid | input | 1 | Access present |
| in_write | input | 1 | Access is a write |
| in_addr | input | 40 | Bus physical address |
| in_data | input | 128 | Data unit (plaintext on write, RAM data on read) |
| out_valid | output | 1 | Registered access present |
| out_write | output | 1 | Write to RAM allowed |
| out_addr | output | 40 | RAM address |
| out_data | output | 128 | Transformed data unit |
| out_ch | output | 1 | Channel used |
| out_enc | output | 1 | Unit went through a channel cipher |
| out_err | output | 1 | Channel refused the access |
| out_tweak | output | 36 | Block index of the RAM address |

## Verification
The bench builds the block with its default parameters: a 40-bit address, 32-bit alias windows at 0x88 and 0xC8, RAM base 0x08 and two channels. With these values the 4 GB window edges sit a single address step from addresses outside the windows, so the edge cases take only a handful of directed accesses. The random mix covers every mode, both key lengths, enabled and disabled channels, and key reloads between accesses. Because the tweak range is 36 bits, a CBC tweak lands in the top data bits and an XEX tweak in the bottom ones, and the bench can tell the two apart.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int BLK_W = 128;
  localparam int KEY_W = 256;

  typedef enum logic [1:0] {
    MODE_ECB  = 2'd0,
    MODE_CBC  = 2'd1,
    MODE_XEX  = 2'd2,
    MODE_RSVD = 2'd3
  } imc_mode_e;

  typedef struct packed {
    imc_mode_e mode;
    logic      k256;
    logic      en;
  } imc_cfg_t;
endpackage

// File: rtl/imc_win_decode.sv
module imc_win_decode #(
  parameter int ADDR_W = 40,
  parameter int WIN_W  = 32,
  parameter int NUM_CH = 2,
  parameter logic [NUM_CH-1:0][ADDR_W-1:0] ALIAS_BASE = {40'hC8_0000_0000, 40'h88_0000_0000},
  parameter logic [ADDR_W-1:0] RAM_BASE = 40'h08_0000_0000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_W-1:0]   ch,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [ADDR_W-5:0] tweak
);
  localparam int TAG_W = ADDR_W - WIN_W;

  logic [NUM_CH-1:0] hit_v;

  // one comparator per alias window
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign hit_v[g] = (addr[ADDR_W-1:WIN_W] == ALIAS_BASE[g][ADDR_W-1:WIN_W]);
  end

  // lowest matching window wins
  always_comb begin
    ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hit_v[i]) ch = CH_W'(i);
    end
  end

  assign hit = |hit_v;
  assign ram_addr = hit ? {RAM_BASE[ADDR_W-1:WIN_W], addr[WIN_W-1:0]} : addr;
  assign tweak = ram_addr[ADDR_W-1:4];

  logic [TAG_W-1:0] unused_ram_lo;
  assign unused_ram_lo = RAM_BASE[ADDR_W-1:WIN_W];
endmodule

// File: rtl/imc_chan_regs.sv
module imc_chan_regs
  import imc_pkg::*;
#(
  parameter int KEY_WORD_W = 32,
  localparam int KEY_WORDS = KEY_W / KEY_WORD_W,
  localparam int KIDX_W = $clog2(KEY_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  imc_cfg_t              cfg_d,
  input  logic                  key_ld,
  input  logic [KIDX_W-1:0]     key_idx,
  input  logic [KEY_WORD_W-1:0] key_word,
  output imc_cfg_t              cfg_q,
  output logic [KEY_W-1:0]      key_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{mode: MODE_ECB, k256: 1'b0, en: 1'b0};
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  // each key word is its own register, loaded from the generator port
  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        key_q[w*KEY_WORD_W +: KEY_WORD_W] <= '0;
      end else if (key_ld && key_idx == KIDX_W'(w)) begin
        key_q[w*KEY_WORD_W +: KEY_WORD_W] <= key_word;
      end
    end
  end
endmodule

// File: rtl/imc_xor_cipher.sv
module imc_xor_cipher
  import imc_pkg::*;
#(
  parameter int TW_W = 36
) (
  input  imc_mode_e         mode,
  input  logic              k256,
  input  logic [KEY_W-1:0]  key,
  input  logic [TW_W-1:0]   tweak,
  input  logic [BLK_W-1:0]  din,
  output logic [BLK_W-1:0]  dout
);
  logic [BLK_W-1:0] key_part;
  logic [BLK_W-1:0] pad;

  assign key_part = k256 ? (key[BLK_W-1:0] ^ key[KEY_W-1:BLK_W]) : key[BLK_W-1:0];

  always_comb begin
    unique case (mode)
      MODE_ECB: pad = key_part;
      MODE_CBC: pad = key_part ^ {tweak, {(BLK_W-TW_W){1'b0}}};
      MODE_XEX: pad = key_part ^ BLK_W'(tweak);
      default:  pad = '0;
    endcase
  end

  assign dout = din ^ pad;
endmodule

// File: rtl/imc_addr_router.sv
module imc_addr_router
  import imc_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int WIN_W      = 32,
  parameter int NUM_CH     = 2,
  parameter int KEY_WORD_W = 32,
  parameter logic [NUM_CH-1:0][ADDR_W-1:0] ALIAS_BASE = {40'hC8_0000_0000, 40'h88_0000_0000},
  parameter logic [ADDR_W-1:0] RAM_BASE = 40'h08_0000_0000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int KIDX_W = $clog2(256 / KEY_WORD_W),
  localparam int TW_W = ADDR_W - 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CH_W-1:0]       cfg_ch,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_k256,
  input  logic                  cfg_en,
  input  logic                  key_ld,
  input  logic [CH_W-1:0]       key_ch,
  input  logic [KIDX_W-1:0]     key_idx,
  input  logic [KEY_WORD_W-1:0] key_word,
  input  logic                  in_valid,
  input  logic                  in_write,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [127:0]          in_data,
  output logic                  out_valid,
  output logic                  out_write,
  output logic [ADDR_W-1:0]     out_addr,
  output logic [127:0]          out_data,
  output logic [CH_W-1:0]       out_ch,
  output logic                  out_enc,
  output logic                  out_err,
  output logic [TW_W-1:0]       out_tweak
);
  imc_cfg_t         cfg_q [NUM_CH];
  logic [KEY_W-1:0] key_q [NUM_CH];
  imc_cfg_t         cfg_d;

  assign cfg_d = '{mode: imc_mode_e'(cfg_mode), k256: cfg_k256, en: cfg_en};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    imc_chan_regs #(.KEY_WORD_W(KEY_WORD_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .cfg_we  (cfg_we && cfg_ch == CH_W'(c)),
      .cfg_d   (cfg_d),
      .key_ld  (key_ld && key_ch == CH_W'(c)),
      .key_idx (key_idx),
      .key_word(key_word),
      .cfg_q   (cfg_q[c]),
      .key_q   (key_q[c])
    );
  end

  logic              hit;
  logic [CH_W-1:0]   ch;
  logic [ADDR_W-1:0] ram_addr;
  logic [TW_W-1:0]   tweak;

  imc_win_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_CH(NUM_CH),
    .ALIAS_BASE(ALIAS_BASE), .RAM_BASE(RAM_BASE)
  ) u_dec (
    .addr(in_addr), .hit(hit), .ch(ch), .ram_addr(ram_addr), .tweak(tweak)
  );

  imc_cfg_t         sel_cfg;
  logic [KEY_W-1:0] sel_key;
  logic [BLK_W-1:0] ciph;
  logic             refuse;

  assign sel_cfg = cfg_q[ch];
  assign sel_key = key_q[ch];
  assign refuse  = hit && (!sel_cfg.en || sel_cfg.mode == MODE_RSVD);

  imc_xor_cipher #(.TW_W(TW_W)) u_ciph (
    .mode (sel_cfg.mode),
    .k256 (sel_cfg.k256),
    .key  (sel_key),
    .tweak(tweak),
    .din  (in_data),
    .dout (ciph)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_write <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      out_ch    <= '0;
      out_enc   <= 1'b0;
      out_err   <= 1'b0;
      out_tweak <= '0;
    end else begin
      out_valid <= in_valid;
      out_write <= in_valid && in_write && !refuse;
      out_addr  <= ram_addr;
      out_ch    <= ch;
      out_tweak <= tweak;
      out_enc   <= in_valid && hit && !refuse;
      out_err   <= in_valid && refuse;
      if (!hit)        out_data <= in_data;
      else if (refuse) out_data <= '0;
      else             out_data <= ciph;
    end
  end
endmodule

module imc_addr_router_chk #(
  parameter int ADDR_W = 40,
  parameter int WIN_W  = 32,
  parameter int NUM_CH = 2,
  parameter logic [NUM_CH-1:0][ADDR_W-1:0] ALIAS_BASE = {40'hC8_0000_0000, 40'h88_0000_0000},
  parameter logic [ADDR_W-1:0] RAM_BASE = 40'h08_0000_0000,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_write,
  input logic [ADDR_W-1:0] in_addr,
  input logic [127:0]      in_data,
  input logic              out_valid,
  input logic              out_write,
  input logic [ADDR_W-1:0] out_addr,
  input logic [127:0]      out_data,
  input logic [CH_W-1:0]   out_ch,
  input logic              out_enc,
  input logic              out_err,
  input logic [ADDR_W-5:0] out_tweak
);
  logic [NUM_CH-1:0] in_hit;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign in_hit[g] = in_addr[ADDR_W-1:WIN_W] == ALIAS_BASE[g][ADDR_W-1:WIN_W];
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R11
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_data == '0 && !out_enc && !out_write));
  // R9
  write_origin_chk: assert property (@(posedge clk) disable iff (rst)
    out_write |-> $past(in_write && in_valid));
  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hit == '0) |=>
      (out_addr == $past(in_addr) && out_data == $past(in_data) && !out_enc && !out_err));
  // R1
  chan_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hit == NUM_CH'(2)) |=> (out_ch == CH_W'(1)));
  // R2
  ram_base_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_hit != '0) |=>
      (out_addr[WIN_W-1:0] == $past(in_addr[WIN_W-1:0]) &&
       out_addr[ADDR_W-1:WIN_W] == RAM_BASE[ADDR_W-1:WIN_W]));
  // R4
  tweak_index_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_enc) |-> (out_tweak == out_addr[ADDR_W-1:4]));
endmodule

bind imc_addr_router imc_addr_router_chk #(
  .ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_CH(NUM_CH),
  .ALIAS_BASE(ALIAS_BASE), .RAM_BASE(RAM_BASE)
) u_chk (.*);

// File: tb/sim_imc_addr_router.sv
`timescale 1ns/1ps
module sim_imc_addr_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         cfg_we = 0, cfg_ch = 0, cfg_k256 = 0, cfg_en = 0;
  logic [1:0]   cfg_mode = 0;
  logic         key_ld = 0, key_ch = 0;
  logic [2:0]   key_idx = 0;
  logic [31:0]  key_word = 0;
  logic         in_valid = 0, in_write = 0;
  logic [39:0]  in_addr = 0;
  logic [127:0] in_data = 0;
  logic         out_valid, out_write, out_enc, out_err;
  logic [0:0]   out_ch;
  logic [39:0]  out_addr;
  logic [127:0] out_data;
  logic [35:0]  out_tweak;

  imc_addr_router u0 (.*);

  int n_cmp = 0, n_bad = 0;
  logic done = 0;

  logic [255:0] bkey [2];
  logic [1:0]   bmode [2];
  logic         bk256 [2];
  logic         ben [2];

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pad_of(int c, logic [35:0] tw);
    logic [127:0] kp = bk256[c] ? (bkey[c][127:0] ^ bkey[c][255:128]) : bkey[c][127:0];
    case (bmode[c])
      2'd0: return kp;
      2'd1: return kp ^ {tw, 92'b0};
      2'd2: return kp ^ {92'b0, tw};
      default: return '0;
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic set_cfg(int c, logic [1:0] m, logic k, logic e);
    cfg_we = 1; cfg_ch = c[0]; cfg_mode = m; cfg_k256 = k; cfg_en = e;
    @(negedge clk);
    cfg_we = 0;
    bmode[c] = m; bk256[c] = k; ben[c] = e;
  endtask

  task automatic load_key(int c, int idx, logic [31:0] w);
    key_ld = 1; key_ch = c[0]; key_idx = idx[2:0]; key_word = w;
    @(negedge clk);
    key_ld = 0;
    bkey[c][idx*32 +: 32] = w;
  endtask

  task automatic access(logic [39:0] a, logic [127:0] d, logic wr, output logic [127:0] got);
    logic w0 = (a[39:32] == 8'h88);
    logic w1 = (a[39:32] == 8'hC8);
    logic win = w0 || w1;
    int c = w0 ? 0 : 1;
    logic [39:0] ra = win ? {8'h08, a[31:0]} : a;
    logic [35:0] tw = ra[39:4];
    logic err = win && (!ben[c] || bmode[c] == 2'd3);
    logic [127:0] ed = !win ? d : err ? '0 : d ^ pad_of(c, tw);
    string tag = !win ? "R3" : err ? "R9" :
                 (bmode[c] == 2'd0) ? "R5/R8" : (bmode[c] == 2'd1) ? "R6/R8" : "R7/R8";
    in_valid = 1; in_write = wr; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 0; in_write = 0;
    got = out_data;
    chk("R11 valid", 128'(out_valid), 128'(1));
    chk("R2 addr", 128'(out_addr), 128'(ra));
    chk({tag, " data"}, out_data, ed);
    chk("R9 err", 128'(out_err), 128'(err));
    chk("R3 enc", 128'(out_enc), 128'(win && !err));
    chk("R9 write", 128'(out_write), 128'(wr && !err));
    if (win) chk("R1 chan", 128'(out_ch), 128'(c));
    if (win && !err) chk("R4 tweak", 128'(out_tweak), 128'(tw));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] got, cipher, plain;
    void'($urandom(32'd2024));
    for (int c = 0; c < 2; c++) begin
      bkey[c] = '0; bmode[c] = 0; bk256[c] = 0; ben[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R11 reset valid", 128'(out_valid), 128'(0));
    chk("R11 reset err", 128'(out_err), 128'(0));
    rst = 0;
    @(negedge clk);
    // R11: channels disabled out of reset, R9 refuses
    access(40'h88_0000_0100, rnd128(), 1'b1, got);
    access(40'hC8_0000_0200, rnd128(), 1'b0, got);
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++) load_key(c, i, $urandom);
    set_cfg(0, 2'd0, 1'b0, 1'b1);
    set_cfg(1, 2'd2, 1'b1, 1'b1);
    access(40'h88_1234_5670, rnd128(), 1'b1, got);
    access(40'hC8_1234_5670, rnd128(), 1'b1, got);
    access(40'h12_3456_7890, rnd128(), 1'b1, got);
    // window edges
    access(40'h88_FFFF_FFF0, rnd128(), 1'b0, got);
    access(40'h89_0000_0000, rnd128(), 1'b0, got);
    access(40'h87_FFFF_FFF0, rnd128(), 1'b0, got);
    access(40'hC8_0000_0000, rnd128(), 1'b0, got);
    access(40'hC7_FFFF_FFF0, rnd128(), 1'b0, got);
    // R8: upper words ignored with short key
    access(40'h88_0000_0400, 128'h5, 1'b0, got);
    plain = got;
    load_key(0, 7, ~bkey[0][255:224]);
    access(40'h88_0000_0400, 128'h5, 1'b0, got);
    chk("R8 upper key ignored", got, plain);
    // R10: loading channel 1 leaves channel 0 alone
    load_key(1, 2, $urandom);
    access(40'h88_0000_0400, 128'h5, 1'b0, got);
    chk("R10 other channel", got, plain);
    set_cfg(0, 2'd1, 1'b1, 1'b1);
    access(40'h88_ABCD_EF00, rnd128(), 1'b1, got);
    set_cfg(0, 2'd2, 1'b0, 1'b1);
    access(40'h88_ABCD_EF00, rnd128(), 1'b1, got);
    set_cfg(0, 2'd3, 1'b0, 1'b1);
    access(40'h88_0000_0010, rnd128(), 1'b1, got);
    set_cfg(1, 2'd1, 1'b0, 1'b0);
    access(40'hC8_0000_0010, rnd128(), 1'b1, got);
    // R11: idle cycle
    @(negedge clk);
    chk("R11 idle", 128'(out_valid), 128'(0));
    // R12 round trip
    set_cfg(1, 2'd2, 1'b1, 1'b1);
    plain = rnd128();
    access(40'hC8_0F0F_0F00, plain, 1'b1, cipher);
    access(40'hC8_0F0F_0F00, cipher, 1'b0, got);
    chk("R12 round trip", got, plain);
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 15);
      if (sel == 0) set_cfg($urandom_range(0, 1), 2'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0));
      else if (sel == 1) load_key($urandom_range(0, 1), $urandom_range(0, 7), $urandom);
      else begin
        logic [39:0] a;
        int k = $urandom_range(0, 2);
        a = {$urandom, $urandom};
        if (k == 0) a[39:32] = 8'h88;
        else if (k == 1) a[39:32] = 8'hC8;
        else if (a[39:32] == 8'h88 || a[39:32] == 8'hC8) a[39] = ~a[39];
        access(a, rnd128(), 1'($urandom), got);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule